// File: doc/BRIEF.md
# Serial Port Hardware and Software Flow Control Gate

This block sits between the receive FIFO, the transmitter and the pins of one serial port in a bridge. It throttles the far end by watching how full the local receive FIFO is. In hardware mode it drives an active-low ready-to-send line. In software mode it raises one-cycle requests to insert a pause character (0x13) or a resume character (0x11) into the transmit stream. It also decides when the local transmitter may begin its next byte. In hardware mode that decision follows the synchronized active-low clear-to-send input, with an allowance of at most two bytes after the far end withdraws it. In software mode it follows the pause and resume characters received from the far end.

The watermark is fixed for each port variant and chosen by a parameter. The enhanced variant has a 320-entry FIFO and a watermark of 191. The standard variant has a 288-entry FIFO and a watermark of 63. Three state machines do the work:

- The receive-side machine has two states. It moves from `RX_ROOM` to `RX_FULL` when occupancy reaches the watermark, and back to `RX_ROOM` when occupancy drops below it.
- The transmit-side machine has three states: `TX_OPEN` (idle, may start), `TX_BUSY` (byte in flight) and `TX_HELD` (stopped by flow control).
  - `TX_OPEN` goes to `TX_BUSY` when a start is accepted, or to `TX_HELD` when a stop condition appears.
  - `TX_BUSY` goes to `TX_HELD` or `TX_OPEN` on the byte-done strobe, depending on whether a stop condition is present.
  - `TX_HELD` goes to `TX_OPEN` when the stop clears, or straight to `TX_BUSY` if a start is accepted in that same cycle.
- A flush returns both machines to `RX_ROOM` and `TX_OPEN`.

Top module: `uart_flow_gate`

## Requirements
- R1: One clock edge after an edge at which the FIFO occupancy is below the watermark, `rts_n` is low, whatever the mode.
- R2: In hardware mode (`mode_sel` = 01), one clock edge after an edge at which the occupancy is at or above the watermark (with no flush), `rts_n` is high.
- R3: The watermark is 191 when `PORT_ENHANCED` = 1 and 63 when `PORT_ENHANCED` = 0.
- R4: `cts_n` passes through a two-stage synchronizer. A change on the pin first affects `tx_permit` after the second rising edge that follows it.
- R5: In hardware mode, while the synchronized `cts_n` is high, at most two byte starts are accepted. After that, `tx_permit` stays low until the synchronized `cts_n` returns low, and that return clears the allowance count. Starts accepted while `cts_n` was low do not count.
- R6: A start is accepted when `tx_start` and `tx_permit` are both high. After an accepted start, `tx_permit` stays low until `tx_done` is seen.
- R7: In none mode (`mode_sel` = 00), `rts_n` stays low and `tx_permit` is never lowered by `cts_n` or by the FIFO level. After reset, `rts_n` is low, both insertion requests are low and `tx_permit` is high.
- R8: In software mode (`mode_sel` = 10), `xoff_req` pulses for one cycle on the edge at which occupancy first reaches the watermark, and `xon_req` pulses for one cycle on the edge at which it first falls below. `rts_n` stays low in this mode.
- R9: In software mode, a received character 0x13 (`rx_char_valid` high) pauses `tx_permit` from the next edge, and 0x11 resumes it. Other characters and `cts_n` have no effect.
- R10: A `flush` strobe returns the block to idle. After the flush edge, `rts_n` is low, no insertion request is pending, the allowance count and any software pause are cleared, and `tx_permit` is high once `flush` is low.
- R11: `mode_sel` = 11 behaves exactly like none mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 00 none, 01 hardware, 10 software, 11 as none |
| rx_level | input | 9 | Receive FIFO occupancy |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| tx_start | input | 1 | Transmitter asks to begin a byte |
| tx_done | input | 1 | Transmitter finished the current byte |
| rx_char_valid | input | 1 | A received character is presented |
| rx_char | input | 8 | Received character |
| flush | input | 1 | Return to idle |
| rts_n | output | 1 | Ready-to-send, active low |
| tx_permit | output | 1 | Transmitter may begin a byte |
| xoff_req | output | 1 | One-cycle request to insert the pause character |
| xon_req | output | 1 | One-cycle request to insert the resume character |

## Verification
The hardest situation to reach is the exhausted overrun allowance, because it needs three things at once: the synchronized clear-to-send is withdrawn, exactly two bytes have been started and completed since then, and the release is timed through the synchronizer. The stimulus first raises the pin and waits out the two synchronizer stages. It then runs two full start/done handshakes and confirms that a third request is refused. Finally it drops the pin and samples `tx_permit` after the first and the second edge, so that both the latency and the clearing of the count are seen. A standard-variant instance shares the inputs, so both watermarks are exercised at their exact boundaries.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_HW   = 2'b01,
        FC_SW   = 2'b10,
        FC_RSVD = 2'b11
    } fc_mode_e;

    typedef enum logic {
        RX_ROOM,
        RX_FULL
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_OPEN,
        TX_BUSY,
        TX_HELD
    } tx_state_e;

    localparam logic [7:0] CHAR_XOFF = 8'h13;
    localparam logic [7:0] CHAR_XON  = 8'h11;

endpackage

// File: rtl/uart_flow_sync.sv
module uart_flow_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= 1'b0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/uart_flow_rxside.sv
module uart_flow_rxside
    import uart_flow_pkg::*;
#(
    parameter int LVL_W     = 9,
    parameter int WATERMARK = 191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fc_mode_e         mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             flush,
    output logic             rts_n,
    output logic             xoff_req,
    output logic             xon_req
);

    localparam logic [LVL_W-1:0] MARK = LVL_W'(WATERMARK);

    rx_state_e state, nxt;
    logic      xoff_q, xon_q;

    always_comb begin
        nxt = state;
        unique case (state)
            RX_ROOM: if (rx_level >= MARK) nxt = RX_FULL;
            RX_FULL: if (rx_level <  MARK) nxt = RX_ROOM;
            default: nxt = RX_ROOM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= RX_ROOM;
            xoff_q <= 1'b0;
            xon_q  <= 1'b0;
        end else if (flush) begin
            state  <= RX_ROOM;
            xoff_q <= 1'b0;
            xon_q  <= 1'b0;
        end else begin
            state  <= nxt;
            xoff_q <= (mode == FC_SW) && (state == RX_ROOM) && (nxt == RX_FULL);
            xon_q  <= (mode == FC_SW) && (state == RX_FULL) && (nxt == RX_ROOM);
        end
    end

    always_comb begin
        rts_n    = (mode == FC_HW) && (state == RX_FULL);
        xoff_req = xoff_q;
        xon_req  = xon_q;
    end

    AST_RTS_BELOW_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level < MARK) |=> !rts_n); // R1

    AST_RTS_AT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FC_HW && rx_level >= MARK && !flush) |=> (rts_n || mode != FC_HW)); // R2

    AST_XOFF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_req |=> !xoff_req); // R8

    AST_XON_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        xon_req |=> !xon_req); // R8

endmodule

// File: rtl/uart_flow_txgate.sv
module uart_flow_txgate
    import uart_flow_pkg::*;
#(
    parameter int ALLOW = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  fc_mode_e   mode,
    input  logic       cts_s,
    input  logic       tx_start,
    input  logic       tx_done,
    input  logic       rx_char_valid,
    input  logic [7:0] rx_char,
    input  logic       flush,
    output logic       tx_permit
);

    localparam int CW = $clog2(ALLOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(ALLOW);

    tx_state_e     state, nxt;
    logic [CW-1:0] sent_cnt;
    logic          paused;
    logic          stop;
    logic          start_ok;

    always_comb begin
        unique case (mode)
            FC_HW:   stop = cts_s && (sent_cnt >= LIMIT);
            FC_SW:   stop = paused;
            default: stop = 1'b0;
        endcase
    end

    always_comb begin
        tx_permit = !flush && (state != TX_BUSY) && !stop;
        start_ok  = tx_start && tx_permit;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_OPEN: begin
                if (start_ok)  nxt = TX_BUSY;
                else if (stop) nxt = TX_HELD;
            end
            TX_BUSY: begin
                if (tx_done) nxt = stop ? TX_HELD : TX_OPEN;
            end
            TX_HELD: begin
                if (start_ok)  nxt = TX_BUSY;
                else if (!stop) nxt = TX_OPEN;
            end
            default: nxt = TX_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= TX_OPEN;
        else if (flush) state <= TX_OPEN;
        else            state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sent_cnt <= '0;
        else if (flush || !cts_s)
            sent_cnt <= '0;
        else if (mode == FC_HW && start_ok && sent_cnt < LIMIT)
            sent_cnt <= sent_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            paused <= 1'b0;
        else if (flush)
            paused <= 1'b0;
        else if (mode == FC_SW && rx_char_valid) begin
            if (rx_char == CHAR_XOFF)     paused <= 1'b1;
            else if (rx_char == CHAR_XON) paused <= 1'b0;
        end
    end

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start && tx_permit) |=> !tx_permit); // R6

    AST_OVERRUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FC_HW && cts_s && sent_cnt == LIMIT) |-> !tx_permit); // R5

    AST_FLUSH_REOPENS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tx_permit || flush)); // R10

    AST_SW_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FC_SW && rx_char_valid && rx_char == CHAR_XOFF && !flush)
            |=> (!tx_permit || mode != FC_SW)); // R9

endmodule

// File: rtl/uart_flow_gate.sv
module uart_flow_gate
    import uart_flow_pkg::*;
#(
    parameter bit PORT_ENHANCED = 1'b1,
    parameter int SYNC_STAGES   = 2,
    parameter int OVERRUN_ALLOW = 2,
    localparam int FIFO_DEPTH   = PORT_ENHANCED ? 320 : 288,
    localparam int WATERMARK    = PORT_ENHANCED ? 191 : 63,
    localparam int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             cts_n,
    input  logic             tx_start,
    input  logic             tx_done,
    input  logic             rx_char_valid,
    input  logic [7:0]       rx_char,
    input  logic             flush,
    output logic             rts_n,
    output logic             tx_permit,
    output logic             xoff_req,
    output logic             xon_req
);

    fc_mode_e mode;
    logic     cts_s;

    assign mode = fc_mode_e'(mode_sel);

    uart_flow_sync #(
        .STAGES (SYNC_STAGES)
    ) u_cts_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_n),
        .q_sync  (cts_s)
    );

    uart_flow_rxside #(
        .LVL_W     (LVL_W),
        .WATERMARK (WATERMARK)
    ) u_rxside (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .rx_level (rx_level),
        .flush    (flush),
        .rts_n    (rts_n),
        .xoff_req (xoff_req),
        .xon_req  (xon_req)
    );

    uart_flow_txgate #(
        .ALLOW (OVERRUN_ALLOW)
    ) u_txgate (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode          (mode),
        .cts_s         (cts_s),
        .tx_start      (tx_start),
        .tx_done       (tx_done),
        .rx_char_valid (rx_char_valid),
        .rx_char       (rx_char),
        .flush         (flush),
        .tx_permit     (tx_permit)
    );

    AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(xoff_req && xon_req)); // R8

    AST_NONE_MODE_RTS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'b00 || mode_sel == 2'b11) |-> !rts_n); // R7

endmodule

// File: tb/uart_flow_gate_tb_top.sv
`timescale 1ns/1ps
module uart_flow_gate_tb_top;

    localparam real CYC = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [8:0] lvl = '0;
    logic       cts_pin = 1'b0;
    logic       req = 1'b0;
    logic       done = 1'b0;
    logic       cv = 1'b0;
    logic [7:0] ch = '0;
    logic       flush = 1'b0;

    logic rts_n, permit, xoff, xon;
    logic s_rts_n, s_permit, s_xoff, s_xon;

    int total = 0;
    int bad = 0;

    always #(CYC/2) clk = ~clk;

    uart_flow_gate #(.PORT_ENHANCED(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .rx_level(lvl),
        .cts_n(cts_pin), .tx_start(req), .tx_done(done),
        .rx_char_valid(cv), .rx_char(ch), .flush(flush),
        .rts_n(rts_n), .tx_permit(permit), .xoff_req(xoff), .xon_req(xon)
    );

    uart_flow_gate #(.PORT_ENHANCED(1'b0)) dut_std_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode), .rx_level(lvl),
        .cts_n(cts_pin), .tx_start(req), .tx_done(done),
        .rx_char_valid(cv), .rx_char(ch), .flush(flush),
        .rts_n(s_rts_n), .tx_permit(s_permit), .xoff_req(s_xoff), .xon_req(s_xon)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start_byte();
        @(negedge clk) req = 1'b1;
        step();
        @(negedge clk) req = 1'b0;
    endtask

    task automatic finish_byte();
        @(negedge clk) done = 1'b1;
        step();
        @(negedge clk) done = 1'b0;
    endtask

    task automatic send_char(input logic [7:0] c);
        @(negedge clk) begin cv = 1'b1; ch = c; end
        step();
        @(negedge clk) cv = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        step();
        chk("R7 reset rts_n", rts_n, 1'b0);
        chk("R7 reset tx_permit", permit, 1'b1);
        chk("R7 reset xoff_req", xoff, 1'b0);
        chk("R7 reset xon_req", xon, 1'b0);
    endtask

    task automatic t_rts_hw();
        @(negedge clk) begin mode = 2'b01; lvl = 9'd190; end
        step();
        chk("R1 hw 190 rts_n", rts_n, 1'b0);
        @(negedge clk) lvl = 9'd191;
        step();
        chk("R2 hw 191 rts_n", rts_n, 1'b1);
        chk("R8 hw no xoff_req", xoff, 1'b0);
        @(negedge clk) lvl = 9'd320;
        step();
        chk("R2 hw 320 rts_n", rts_n, 1'b1);
        @(negedge clk) lvl = 9'd190;
        step();
        chk("R1 hw back to 190 rts_n", rts_n, 1'b0);
        chk("R8 hw no xon_req", xon, 1'b0);
        @(negedge clk) lvl = 9'd0;
        step();
    endtask

    task automatic t_variant();
        @(negedge clk) begin mode = 2'b01; lvl = 9'd62; end
        step();
        chk("R3 standard 62 rts_n", s_rts_n, 1'b0);
        @(negedge clk) lvl = 9'd63;
        step();
        chk("R3 standard 63 rts_n", s_rts_n, 1'b1);
        chk("R3 enhanced 63 rts_n", rts_n, 1'b0);
        @(negedge clk) lvl = 9'd0;
        step();
        chk("R1 standard 0 rts_n", s_rts_n, 1'b0);
    endtask

    task automatic t_cts_overrun();
        @(negedge clk) mode = 2'b01;
        step();
        start_byte();
        finish_byte();
        chk("R5 start before cts high", permit, 1'b1);
        @(negedge clk) cts_pin = 1'b1;
        step();
        step();
        chk("R5 permit with zero used", permit, 1'b1);
        start_byte();
        chk("R6 permit low while busy", permit, 1'b0);
        finish_byte();
        chk("R5 permit after one byte", permit, 1'b1);
        start_byte();
        finish_byte();
        chk("R5 held after two bytes", permit, 1'b0);
        @(negedge clk) req = 1'b1;
        step();
        step();
        chk("R5 third request refused", permit, 1'b0);
        @(negedge clk) begin req = 1'b0; cts_pin = 1'b0; end
        step();
        chk("R4 first edge still held", permit, 1'b0);
        step();
        chk("R4 second edge released", permit, 1'b1);
        @(negedge clk) cts_pin = 1'b1;
        step();
        step();
        step();
        chk("R5 count cleared after cts low", permit, 1'b1);
        @(negedge clk) cts_pin = 1'b0;
        step();
        step();
    endtask

    task automatic t_none();
        @(negedge clk) begin mode = 2'b00; cts_pin = 1'b1; lvl = 9'd300; end
        step();
        step();
        step();
        chk("R7 none rts_n above mark", rts_n, 1'b0);
        chk("R7 none permit with cts high", permit, 1'b1);
        for (int k = 0; k < 3; k++) begin
            start_byte();
            finish_byte();
            chk("R7 none permit after byte", permit, 1'b1);
        end
        @(negedge clk) mode = 2'b11;
        step();
        chk("R11 mode 11 rts_n", rts_n, 1'b0);
        chk("R11 mode 11 permit", permit, 1'b1);
        @(negedge clk) begin mode = 2'b00; lvl = 9'd0; cts_pin = 1'b0; end
        step();
        step();
    endtask

    task automatic t_sw();
        @(negedge clk) mode = 2'b10;
        step();
        @(negedge clk) lvl = 9'd191;
        step();
        chk("R8 xoff_req on crossing", xoff, 1'b1);
        chk("R8 sw rts_n stays low", rts_n, 1'b0);
        chk("R8 no xon on crossing", xon, 1'b0);
        step();
        chk("R8 xoff_req one cycle", xoff, 1'b0);
        @(negedge clk) lvl = 9'd190;
        step();
        chk("R8 xon_req on falling", xon, 1'b1);
        step();
        chk("R8 xon_req one cycle", xon, 1'b0);
        send_char(8'h13);
        chk("R9 paused by 0x13", permit, 1'b0);
        send_char(8'h41);
        chk("R9 other char ignored", permit, 1'b0);
        send_char(8'h11);
        chk("R9 resumed by 0x11", permit, 1'b1);
        @(negedge clk) cts_pin = 1'b1;
        step();
        step();
        step();
        for (int k = 0; k < 3; k++) begin
            start_byte();
            finish_byte();
            chk("R9 sw ignores cts", permit, 1'b1);
        end
        @(negedge clk) begin cts_pin = 1'b0; lvl = 9'd0; end
        step();
        step();
    endtask

    task automatic t_flush();
        @(negedge clk) begin mode = 2'b01; lvl = 9'd200; end
        step();
        chk("R2 pre-flush rts_n", rts_n, 1'b1);
        @(negedge clk) cts_pin = 1'b1;
        step();
        step();
        start_byte();
        finish_byte();
        start_byte();
        finish_byte();
        chk("R5 pre-flush held", permit, 1'b0);
        @(negedge clk) flush = 1'b1;
        step();
        @(negedge clk) flush = 1'b0;
        #1;
        chk("R10 flush rts_n low", rts_n, 1'b0);
        chk("R10 flush permit high", permit, 1'b1);
        chk("R10 flush no xoff", xoff, 1'b0);
        chk("R10 flush no xon", xon, 1'b0);
        step();
        chk("R2 rts_n re-raised after flush", rts_n, 1'b1);
        @(negedge clk) mode = 2'b10;
        send_char(8'h13);
        chk("R9 pre-flush paused", permit, 1'b0);
        @(negedge clk) flush = 1'b1;
        step();
        @(negedge clk) flush = 1'b0;
        #1;
        chk("R10 flush clears pause", permit, 1'b1);
        chk("R10 flush sw rts_n", rts_n, 1'b0);
        @(negedge clk) begin cts_pin = 1'b0; lvl = 9'd0; mode = 2'b00; end
        step();
        step();
    endtask

    initial begin
        t_reset();
        t_rts_hw();
        t_variant();
        t_cts_overrun();
        t_none();
        t_sw();
        t_flush();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end

    initial begin
        #(CYC * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end

endmodule